// File: doc/BRIEF.md
# Memory-Card Host Interrupt and DMA Request Router

This block collects the event flags of a memory-card host controller into a 13-bit request register and turns them into one processor interrupt line and two DMA request lines, one for the receive FIFO and one for the transmit FIFO. Each request bit has a mask bit. Software clears request bits by writing ones to the request register. When the DMA-enable bit of the configuration register is set, the two FIFO service requests leave the interrupt path and drive the DMA lines instead.

The block also owns the card-clock control. A clock-control write starts or stops the card clock and keeps the clock-enable status bit. A stop aborts the active transfer and raises the clock-off request. A write to the configuration register marks a command as pending. The pending command is launched when the clock is running and the stop-transfer bit of the configuration is clear. All registers sit behind a small single-cycle write/read port. Outputs change on the clock edge that registers a write or an event.

Top module: `card_irq_router`

## Requirements
- R1: After reset, the request, mask and configuration registers read zero, the clock-enable status reads zero, and `irq`, `dma_rx_req`, `dma_tx_req`, `cmd_launch` and `xfer_abort` are low.
- R2: A high `evt_set[i]` sets request bit i at the next clock edge. The bit order is: 0 data done, 1 program done, 2 end of command, 3 stop command, 4 clock off, 5 receive FIFO, 6 transmit FIFO, 7 timeout, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card acknowledge.
- R3: Writing the request register (address 4) clears each request bit whose write-data bit is one. If an event strobe and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: The mask register (address 3, 13 bits) reads back what was written. `irq` is high exactly when some request bit is set and its mask bit is clear. A mask write takes effect at the edge that registers it.
- R5: Configuration bit 7 (address 2) is the DMA enable. While it is set, request bits 5 and 6 do not drive `irq`, `dma_rx_req` equals request bit 5 and `dma_tx_req` equals request bit 6. While it is clear, both DMA lines are low.
- R6: A clock-control write (address 0) with bit 1 set sets the clock-enable status (address 1, bit 8) and clears request bit 4.
- R7: A clock-control write with bit 0 set clears the clock-enable status, sets request bit 4 and pulses `xfer_abort` for one cycle. When bits 0 and 1 are both written, the stop takes effect and no command launches.
- R8: A configuration write marks a command pending. It pulses `cmd_launch` at once if the clock is enabled and the new bit 10 (stop transfer) is clear. Otherwise a later start-clock write launches it, provided stored bit 10 is clear. Each launch consumes the pending mark.
- R9: The configuration register keeps 14 bits and reads back at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_set | input | 13 | Event strobes, one per request bit |
| irq | output | 1 | Processor interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| clk_en | output | 1 | Card clock enabled |
| cmd_launch | output | 1 | One-cycle pulse that launches the pending command |
| xfer_abort | output | 1 | One-cycle pulse that aborts the active transfer |

## Verification
Three pairs of functions can fall in the same cycle. An event strobe can meet a software clear of the same bit. An event on request bit 4 can meet a start-clock write that clears it. A start and a stop can arrive in one clock-control word. The bench provokes each pair by driving the event strobe in the same cycle as the write, or by writing both clock bits in one word. It then judges the result at the ports: it reads back the request register, watches `irq`, and checks that `clk_en` is low and `cmd_launch` stays quiet.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int NREQ      = 13;
  localparam int CFG_W     = 14;
  localparam int BIT_CLKOFF = 4;
  localparam int BIT_RXREQ = 5;
  localparam int BIT_TXREQ = 6;
  localparam int CFG_DMA   = 7;
  localparam int CFG_STOP  = 10;
  localparam int STAT_CLKEN = 8;
  localparam int CLK_STOP  = 0;
  localparam int CLK_START = 1;

  typedef enum logic [2:0] {
    SEL_CLKCTL = 3'd0,
    SEL_STATUS = 3'd1,
    SEL_CONFIG = 3'd2,
    SEL_MASK   = 3'd3,
    SEL_REQ    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/cirq_req_bank.sv
module cirq_req_bank #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] hw_clr,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] evt_set,
  output logic [N-1:0] req_q
);
  logic [N-1:0] req_d;
  logic         req_ce;

  always_comb begin
    req_d  = (req_q & ~(sw_clr | hw_clr)) | hw_set | evt_set;
    req_ce = |{sw_clr, hw_clr, hw_set, evt_set};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_ce) req_q <= req_d;
  end
endmodule

// File: rtl/cirq_clk_ctrl.sv
module cirq_clk_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_clkctl,
  input  logic start_bit,
  input  logic stop_bit,
  input  logic wr_cfg,
  input  logic new_cfg_stop,
  input  logic cur_cfg_stop,
  output logic clk_en,
  output logic cmd_launch,
  output logic xfer_abort,
  output logic clkoff_set,
  output logic clkoff_clr
);
  logic do_start, do_stop;
  logic clk_en_d, pend_q, pend_d, launch_d;
  logic state_ce;

  always_comb begin
    do_start   = wr_clkctl && start_bit;
    do_stop    = wr_clkctl && stop_bit;
    clkoff_set = do_stop;
    clkoff_clr = do_start && !do_stop;
    launch_d   = !do_stop &&
                 ((wr_cfg && !new_cfg_stop && clk_en) ||
                  (do_start && pend_q && !cur_cfg_stop));
    if (do_stop)       clk_en_d = 1'b0;
    else if (do_start) clk_en_d = 1'b1;
    else               clk_en_d = clk_en;
    if (launch_d)    pend_d = 1'b0;
    else if (wr_cfg) pend_d = 1'b1;
    else             pend_d = pend_q;
    state_ce = wr_clkctl || wr_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en <= 1'b0;
      pend_q <= 1'b0;
    end else if (state_ce) begin
      clk_en <= clk_en_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_launch <= 1'b0;
      xfer_abort <= 1'b0;
    end else begin
      cmd_launch <= launch_d;
      xfer_abort <= do_stop;
    end
  end
endmodule

// File: rtl/cirq_route.sv
module cirq_route #(
  parameter int N = 13,
  parameter int RX_BIT = 5,
  parameter int TX_BIT = 6
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] mask,
  input  logic         dma_en,
  output logic         irq,
  output logic         dma_rx_req,
  output logic         dma_tx_req
);
  logic [N-1:0] eff_mask;

  for (genvar i = 0; i < N; i++) begin : g_mask
    if (i == RX_BIT || i == TX_BIT) begin : g_fifo
      assign eff_mask[i] = mask[i] | dma_en;
    end else begin : g_plain
      assign eff_mask[i] = mask[i];
    end
  end

  assign irq        = |(req & ~eff_mask);
  assign dma_rx_req = dma_en & req[RX_BIT];
  assign dma_tx_req = dma_en & req[TX_BIT];
endmodule

// File: rtl/card_irq_router.sv
module card_irq_router
  import cirq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NREQ-1:0]   evt_set,
  output logic              irq,
  output logic              dma_rx_req,
  output logic              dma_tx_req,
  output logic              clk_en,
  output logic              cmd_launch,
  output logic              xfer_abort
);
  logic [NREQ-1:0]  req_q, mask_q, sw_clr, hw_set, hw_clr;
  logic [CFG_W-1:0] cfg_q;
  logic wr_clkctl, wr_cfg, wr_mask, wr_req;
  logic clkoff_set, clkoff_clr;

  always_comb begin
    wr_clkctl = reg_wr && (reg_addr == ADDR_W'(SEL_CLKCTL));
    wr_cfg    = reg_wr && (reg_addr == ADDR_W'(SEL_CONFIG));
    wr_mask   = reg_wr && (reg_addr == ADDR_W'(SEL_MASK));
    wr_req    = reg_wr && (reg_addr == ADDR_W'(SEL_REQ));
    sw_clr    = wr_req ? reg_wdata[NREQ-1:0] : '0;
    hw_set    = '0;
    hw_clr    = '0;
    hw_set[BIT_CLKOFF] = clkoff_set;
    hw_clr[BIT_CLKOFF] = clkoff_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata[NREQ-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_cfg) cfg_q <= reg_wdata[CFG_W-1:0];
  end

  cirq_req_bank #(.N(NREQ)) u_bank (
    .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .hw_clr(hw_clr),
    .hw_set(hw_set), .evt_set(evt_set), .req_q(req_q)
  );

  cirq_clk_ctrl u_clk (
    .clk(clk), .rst_n(rst_n), .wr_clkctl(wr_clkctl),
    .start_bit(reg_wdata[CLK_START]), .stop_bit(reg_wdata[CLK_STOP]),
    .wr_cfg(wr_cfg), .new_cfg_stop(reg_wdata[CFG_STOP]),
    .cur_cfg_stop(cfg_q[CFG_STOP]), .clk_en(clk_en),
    .cmd_launch(cmd_launch), .xfer_abort(xfer_abort),
    .clkoff_set(clkoff_set), .clkoff_clr(clkoff_clr)
  );

  cirq_route #(.N(NREQ), .RX_BIT(BIT_RXREQ), .TX_BIT(BIT_TXREQ)) u_route (
    .req(req_q), .mask(mask_q), .dma_en(cfg_q[CFG_DMA]),
    .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(SEL_STATUS): reg_rdata[STAT_CLKEN] = clk_en;
      ADDR_W'(SEL_CONFIG): reg_rdata[CFG_W-1:0]  = cfg_q;
      ADDR_W'(SEL_MASK):   reg_rdata[NREQ-1:0]   = mask_q;
      ADDR_W'(SEL_REQ):    reg_rdata[NREQ-1:0]   = req_q;
      default:             reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cirq_checker.sv
module cirq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] evt_set,
  input logic [12:0] req_q,
  input logic [12:0] mask_q,
  input logic [13:0] cfg_q,
  input logic        wr_clkctl,
  input logic [31:0] reg_wdata,
  input logic        irq,
  input logic        dma_rx_req,
  input logic        dma_tx_req,
  input logic        clk_en,
  input logic        cmd_launch,
  input logic        xfer_abort
);
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((req_q & $past(evt_set)) == $past(evt_set))); // R3
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(req_q & ~mask_q))); // R4
  AST_DMA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[7] |-> !(dma_rx_req || dma_tx_req)); // R5
  AST_STOP_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clkctl && reg_wdata[0]) |=> (!clk_en && req_q[4] && xfer_abort)); // R7
  AST_LAUNCH_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_launch |-> clk_en); // R8
  AST_LAUNCH_NOSTOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_launch |-> !cfg_q[10]); // R8
endmodule

bind card_irq_router cirq_checker u_cirq_checker (
  .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .req_q(req_q),
  .mask_q(mask_q), .cfg_q(cfg_q), .wr_clkctl(wr_clkctl),
  .reg_wdata(reg_wdata), .irq(irq), .dma_rx_req(dma_rx_req),
  .dma_tx_req(dma_tx_req), .clk_en(clk_en), .cmd_launch(cmd_launch),
  .xfer_abort(xfer_abort)
);

// File: tb/card_irq_router_bench.sv
module card_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [12:0] evt_set = '0;
  logic irq, dma_rx_req, dma_tx_req, clk_en, cmd_launch, xfer_abort;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  card_irq_router u_card_irq_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
    .clk_en(clk_en), .cmd_launch(cmd_launch), .xfer_abort(xfer_abort)
  );

  // entry: wr, addr, wdata[15:0], evt[12:0], exp {irq, rx, tx}
  localparam int NV = 12;
  localparam logic [35:0] VEC [0:NV-1] = '{
    {1'b0, 3'd0, 16'h0000, 13'h0001, 3'b100}, // R2 data done
    {1'b1, 3'd4, 16'h0001, 13'h0000, 3'b000}, // R3 clear
    {1'b1, 3'd3, 16'h0004, 13'h0004, 3'b000}, // R4 masked
    {1'b1, 3'd3, 16'h0000, 13'h0000, 3'b100}, // R4 unmask
    {1'b1, 3'd4, 16'h0004, 13'h0000, 3'b000}, // R3
    {1'b0, 3'd0, 16'h0000, 13'h0020, 3'b100}, // R5 rx, dma off
    {1'b1, 3'd2, 16'h0080, 13'h0000, 3'b010}, // R5 dma on
    {1'b0, 3'd0, 16'h0000, 13'h0040, 3'b011}, // R5 tx
    {1'b1, 3'd4, 16'h0020, 13'h0000, 3'b001}, // R5
    {1'b0, 3'd0, 16'h0000, 13'h0100, 3'b101}, // R2 data error
    {1'b1, 3'd2, 16'h0000, 13'h0000, 3'b100}, // R5 dma off
    {1'b1, 3'd4, 16'h0140, 13'h0000, 3'b000}  // R3
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d,
                     input logic [12:0] e);
    reg_wr = wr; reg_addr = a; reg_wdata = d; evt_set = e;
    @(negedge clk);
    reg_wr = 1'b0; evt_set = '0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {26'b0, irq, dma_rx_req, dma_tx_req, clk_en, cmd_launch, xfer_abort}, 32'h0);
    rd("R1 req", 3'd4, 32'h0);
    rd("R1 mask", 3'd3, 32'h0);
    rd("R1 cfg", 3'd2, 32'h0);
    rd("R1 status", 3'd1, 32'h0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][35], VEC[i][34:32], {16'h0, VEC[i][31:16]}, VEC[i][15:3]);
      chk($sformatf("R2/R3/R4/R5 vector %0d", i),
          {29'b0, irq, dma_rx_req, dma_tx_req}, {29'b0, VEC[i][2:0]});
    end
    rd("R9 cfg readback", 3'd2, 32'h0);
    rd("R4 mask readback", 3'd3, 32'h0);
    cyc(1'b1, 3'd2, 32'h3A55, 13'h0);  // R9 14-bit store; stop bit 10 clear? 0x3A55 has bit10 clear
    rd("R9 cfg 14 bits", 3'd2, 32'h3A55);
    cyc(1'b1, 3'd2, 32'h0000, 13'h0);
    cyc(1'b1, 3'd3, 32'hFFFF, 13'h0);
    rd("R4 mask 13 bits", 3'd3, 32'h1FFF);
    cyc(1'b1, 3'd3, 32'h0, 13'h0);

    // R3 event beats clear on same bit
    cyc(1'b0, 3'd0, 32'h0, 13'h0008);
    cyc(1'b1, 3'd4, 32'h0008, 13'h0008);
    rd("R3 event wins", 3'd4, 32'h0008);
    chk("R3 irq stays", {31'b0, irq}, 32'h1);
    cyc(1'b1, 3'd4, 32'h0008, 13'h0);
    chk("R3 cleared", {31'b0, irq}, 32'h0);

    // R6/R8 start clock launches pending command (pending from earlier config writes)
    cyc(1'b1, 3'd0, 32'h2, 13'h0);
    chk("R6 clk_en", {31'b0, clk_en}, 32'h1);
    chk("R8 launch on start", {31'b0, cmd_launch}, 32'h1);
    rd("R6 status", 3'd1, 32'h100);
    cyc(1'b1, 3'd0, 32'h2, 13'h0);
    chk("R8 pending consumed", {31'b0, cmd_launch}, 32'h0);

    // R8 config write with clock on
    cyc(1'b1, 3'd2, 32'h0400, 13'h0);
    chk("R8 no launch stop bit", {31'b0, cmd_launch}, 32'h0);
    cyc(1'b1, 3'd0, 32'h2, 13'h0);
    chk("R8 start blocked by stop bit", {31'b0, cmd_launch}, 32'h0);
    cyc(1'b1, 3'd2, 32'h0000, 13'h0);
    chk("R8 immediate launch", {31'b0, cmd_launch}, 32'h1);
    @(negedge clk);
    chk("R8 launch one cycle", {31'b0, cmd_launch}, 32'h0);

    // R7 stop clock
    cyc(1'b1, 3'd0, 32'h1, 13'h0);
    chk("R7 clk_en low", {31'b0, clk_en}, 32'h0);
    chk("R7 abort pulse", {31'b0, xfer_abort}, 32'h1);
    chk("R7 irq clock off", {31'b0, irq}, 32'h1);
    rd("R7 req bit4", 3'd4, 32'h0010);
    @(negedge clk);
    chk("R7 abort one cycle", {31'b0, xfer_abort}, 32'h0);

    // R6 start clears clock-off; R3 event on bit4 beats the start clear
    cyc(1'b1, 3'd0, 32'h2, 13'h0010);
    rd("R3 event beats start clear", 3'd4, 32'h0010);
    cyc(1'b1, 3'd0, 32'h2, 13'h0);
    rd("R6 clock-off cleared", 3'd4, 32'h0);
    chk("R6 irq low", {31'b0, irq}, 32'h0);

    // R7 start and stop together: stop wins, no launch
    cyc(1'b1, 3'd0, 32'h1, 13'h0);
    cyc(1'b1, 3'd2, 32'h0000, 13'h0);  // pending, clock off: no launch
    chk("R8 no launch clock off", {31'b0, cmd_launch}, 32'h0);
    cyc(1'b1, 3'd0, 32'h3, 13'h0);
    chk("R7 both bits clk_en", {31'b0, clk_en}, 32'h0);
    chk("R7 both bits no launch", {31'b0, cmd_launch}, 32'h0);
    chk("R7 both bits abort", {31'b0, xfer_abort}, 32'h1);
    rd("R7 both bits req4", 3'd4, 32'h0010);
    cyc(1'b1, 3'd0, 32'h2, 13'h0);
    chk("R8 pending kept after stop", {31'b0, cmd_launch}, 32'h1);

    // R4 mask takes effect at once on held request
    cyc(1'b0, 3'd0, 32'h0, 13'h0200);
    chk("R4 irq raised", {31'b0, irq}, 32'h1);
    cyc(1'b1, 3'd3, 32'h0200, 13'h0);
    chk("R4 irq masked", {31'b0, irq}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule